// File: doc/BRIEF.md
# Byte-Serial Subtract-Immediate Decoder

This block sits at the front of an instruction pipeline. It takes a variable-length instruction stream one byte per cycle over a valid/ready handshake. It picks out the immediate forms of integer subtract: the two short accumulator opcodes (0x2C, 0x2D) and the two ModRM group opcodes (0x80, 0x81).

Before the opcode it tracks three optional prefixes:
- a bus-lock byte;
- an operand-size override;
- in 64-bit mode, a REX byte.

For the group opcodes it collects the ModRM byte, then the one, two or four immediate bytes. It then presents a single decoded record for one cycle. The record holds:
- the operand size;
- whether the destination is memory or a register;
- the register number;
- a flag for the legacy high-byte registers;
- the immediate, sign-extended;
- an is-subtract indication;
- an undefined-opcode fault.

A memory destination is only flagged: no address bytes are parsed. Any opcode outside the four ends the instruction at once, so the decoder stays aligned with the stream.

Top module: `subimm_decoder`

## Requirements
- R1: While scanning for an opcode, byte 0xF0 records a lock request and byte 0x66 records a 16-bit size override. In 64-bit mode a byte from 0x40 to 0x4F is a REX prefix. Its bit 3 is W and its bit 0 is B. A REX prefix counts only when it is the last prefix before the opcode: a later 0xF0 or 0x66 cancels it.
- R2: Opcode 0x2C takes one immediate byte. It yields size code 0 (8-bit), a register destination and register 0.
- R3: Opcode 0x2D yields register 0. Its size code is 3 (64-bit, four immediate bytes) when REX.W is present. Otherwise it is 1 (16-bit, two bytes) after 0x66, or else 2 (32-bit, four bytes). REX.W wins over 0x66.
- R4: Opcodes 0x80 (8-bit, one immediate byte) and 0x81 (size chosen as in R3) read a ModRM byte whose mod is bits 7:6, reg is bits 5:3 and rm is bits 2:0. The record marks subtract only when reg equals 5, and a memory destination when mod is not 3. For every other reg value the immediate bytes are still consumed.
- R5: With mod equal to 3, the register number is {REX.B, rm}; with a memory destination it is 0. The high-byte flag is set only for an 8-bit register destination with no REX prefix and rm from 4 to 7.
- R6: Immediate bytes arrive least significant first. The record carries the immediate sign-extended from its top bit to all 64 output bits.
- R7: A lock request with a register destination, including both accumulator opcodes, sets the fault flag and clears is-subtract. A lock request with a memory destination gives no fault.
- R8: A byte is taken only in a cycle where in_valid and in_ready are both high. in_ready is low in the cycle the record is presented. Bytes offered while in_valid is low change nothing.
- R9: out_valid is high for exactly one cycle, the cycle after the last byte of the instruction is taken. The decoder then scans for prefixes again with all prefixes cleared.
- R10: Any other opcode byte, including 0x40 to 0x4F outside 64-bit mode, at once yields a record with size code 0, register destination 0, zero immediate, and is-subtract and fault both low.
- R11: A synchronous reset drops any partly decoded instruction and its prefixes. It holds out_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_64 | input | 1 | High when the core runs in 64-bit mode |
| in_valid | input | 1 | Instruction byte is offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder can take a byte |
| out_valid | output | 1 | Decoded record is present this cycle |
| out_size | output | 2 | Operand size: 0=8, 1=16, 2=32, 3=64 bits |
| out_mem | output | 1 | Destination is memory |
| out_reg | output | 4 | Destination register number |
| out_hibyte | output | 1 | Register is a legacy high-byte register |
| out_is_sub | output | 1 | Instruction is an immediate subtract |
| out_fault | output | 1 | Undefined-opcode fault |
| out_imm | output | OUT_W | Sign-extended immediate |

## Verification
The bench sweeps every ModRM value for both group opcodes, with and without REX, and with each operand-size combination. This catches a decoder that mixes up the mod/reg/rm fields, drops REX.B, or flags high-byte registers when REX is present. It also runs all 256 one-byte immediates and boundary 16- and 32-bit values: sign extension taken from the wrong byte shows up as a wrong upper half. Directed cases cover the following:
- a REX byte followed by 0x66, which must cancel the REX;
- lock with register and with memory destinations, where a decoder that tests the wrong condition faults legal code;
- REX bytes outside 64-bit mode;
- idle gaps carrying junk bytes;
- reset in the middle of an instruction, where a decoder that keeps stale prefixes gives the wrong size afterwards.

// File: rtl/subdec_pkg.sv
`timescale 1ns/1ps
package subdec_pkg;

   typedef enum logic [1:0] {
      OSZ_8  = 2'd0,
      OSZ_16 = 2'd1,
      OSZ_32 = 2'd2,
      OSZ_64 = 2'd3
   } osz_e;

   typedef enum logic [1:0] {
      ST_SCAN,
      ST_MODRM,
      ST_IMM,
      ST_EMIT
   } dstate_e;

   typedef struct packed {
      osz_e       size;
      logic       mem;
      logic [3:0] regn;
      logic       hibyte;
      logic       is_sub;
      logic       fault;
   } rec_t;

   localparam logic [7:0] BYTE_LOCK = 8'hF0;
   localparam logic [7:0] BYTE_OSZ  = 8'h66;
   localparam logic [3:0] REX_HI    = 4'h4;
   localparam logic [7:0] OP_ACC8   = 8'h2C;
   localparam logic [7:0] OP_ACCW   = 8'h2D;
   localparam logic [7:0] OP_GRP8   = 8'h80;
   localparam logic [7:0] OP_GRPW   = 8'h81;
   localparam logic [2:0] SUB_EXT   = 3'd5;
   localparam logic [1:0] MOD_REG   = 2'b11;

   // immediate byte count for a given operand size
   function automatic logic [2:0] imm_len(osz_e s);
      case (s)
         OSZ_8:   imm_len = 3'd1;
         OSZ_16:  imm_len = 3'd2;
         default: imm_len = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/subdec_prefix.sv
`timescale 1ns/1ps
module subdec_prefix
   import subdec_pkg::*;
#(
   parameter bit REX_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       mode_64,
   input  logic       take,
   input  logic       clr,
   input  logic [7:0] byte_in,
   output logic       is_prefix,
   output logic       lock,
   output logic       osz16,
   output logic       rex_seen,
   output logic       rex_w,
   output logic       rex_b
);

   logic hit_lock, hit_osz, hit_rex;

   assign hit_lock = (byte_in == BYTE_LOCK);
   assign hit_osz  = (byte_in == BYTE_OSZ);

   generate
      if (REX_EN) begin : g_rex
         assign hit_rex = mode_64 && (byte_in[7:4] == REX_HI);
      end else begin : g_norex
         assign hit_rex = 1'b0;
      end
   endgenerate

   assign is_prefix = hit_lock | hit_osz | hit_rex;

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         lock     <= 1'b0;
         osz16    <= 1'b0;
         rex_seen <= 1'b0;
         rex_w    <= 1'b0;
         rex_b    <= 1'b0;
      end else if (take) begin
         if (hit_lock) lock  <= 1'b1;
         if (hit_osz)  osz16 <= 1'b1;
         if (hit_rex) begin
            rex_seen <= 1'b1;
            rex_w    <= byte_in[3];
            rex_b    <= byte_in[0];
         end else if (hit_lock || hit_osz) begin
            // REX only counts directly in front of the opcode
            rex_seen <= 1'b0;
            rex_w    <= 1'b0;
            rex_b    <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/subdec_immcol.sv
`timescale 1ns/1ps
module subdec_immcol #(
   parameter int LANES = 4,
   parameter int OUT_W = 64,
   localparam int CW   = $clog2(LANES + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             load,
   input  logic [7:0]       byte_in,
   input  logic [CW-1:0]    len,
   output logic             last,
   output logic [OUT_W-1:0] value
);

   logic [LANES*8-1:0] raw;
   logic [CW-1:0]      cnt;
   logic               sgn;

   always_ff @(posedge clk) begin
      if (rst || clr)
         cnt <= '0;
      else if (load)
         cnt <= cnt + CW'(1);
   end

   genvar k;
   generate
      for (k = 0; k < LANES; k++) begin : g_lane
         always_ff @(posedge clk) begin
            if (rst || clr)
               raw[k*8 +: 8] <= 8'h00;
            else if (load && (cnt == CW'(k)))
               raw[k*8 +: 8] <= byte_in;
         end
      end
   endgenerate

   assign last = ((cnt + CW'(1)) == len);

   always_comb begin
      sgn = 1'b0;
      for (int j = 0; j < LANES; j++)
         if (CW'(j + 1) == len) sgn = raw[j*8 + 7];
      value = {OUT_W{sgn}};
      for (int j = 0; j < LANES; j++)
         if (CW'(j) < len) value[j*8 +: 8] = raw[j*8 +: 8];
   end

endmodule

// File: rtl/subdec_ctrl.sv
`timescale 1ns/1ps
module subdec_ctrl
   import subdec_pkg::*;
#(
   parameter int LW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [7:0]    byte_in,
   input  logic          is_prefix,
   input  logic          lock,
   input  logic          osz16,
   input  logic          rex_seen,
   input  logic          rex_w,
   input  logic          rex_b,
   input  logic          imm_last,
   output logic          in_ready,
   output logic          out_valid,
   output logic          pfx_take,
   output logic          imm_load,
   output logic          clr,
   output logic [LW-1:0] len,
   output rec_t          rec
);

   dstate_e st;
   osz_e    wide_sz;
   logic    take;
   logic    regmem;

   assign in_ready  = (st != ST_EMIT);
   assign out_valid = (st == ST_EMIT);
   assign clr       = (st == ST_EMIT);
   assign take      = in_valid && in_ready;
   assign pfx_take  = take && (st == ST_SCAN) && is_prefix;
   assign imm_load  = take && (st == ST_IMM);
   assign regmem    = (byte_in[7:6] != MOD_REG);

   always_comb begin
      if (rex_w)      wide_sz = OSZ_64;
      else if (osz16) wide_sz = OSZ_16;
      else            wide_sz = OSZ_32;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st  <= ST_SCAN;
         rec <= '0;
         len <= '0;
      end else begin
         case (st)
            ST_SCAN: begin
               if (take && !is_prefix) begin
                  rec.mem    <= 1'b0;
                  rec.regn   <= 4'd0;
                  rec.hibyte <= 1'b0;
                  case (byte_in)
                     OP_ACC8: begin
                        rec.size   <= OSZ_8;
                        rec.is_sub <= !lock;
                        rec.fault  <= lock;
                        len        <= LW'(imm_len(OSZ_8));
                        st         <= ST_IMM;
                     end
                     OP_ACCW: begin
                        rec.size   <= wide_sz;
                        rec.is_sub <= !lock;
                        rec.fault  <= lock;
                        len        <= LW'(imm_len(wide_sz));
                        st         <= ST_IMM;
                     end
                     OP_GRP8: begin
                        rec.size   <= OSZ_8;
                        rec.is_sub <= 1'b0;
                        rec.fault  <= 1'b0;
                        len        <= LW'(imm_len(OSZ_8));
                        st         <= ST_MODRM;
                     end
                     OP_GRPW: begin
                        rec.size   <= wide_sz;
                        rec.is_sub <= 1'b0;
                        rec.fault  <= 1'b0;
                        len        <= LW'(imm_len(wide_sz));
                        st         <= ST_MODRM;
                     end
                     default: begin
                        rec.size   <= OSZ_8;
                        rec.is_sub <= 1'b0;
                        rec.fault  <= 1'b0;
                        len        <= '0;
                        st         <= ST_EMIT;
                     end
                  endcase
               end
            end
            ST_MODRM: begin
               if (take) begin
                  rec.mem    <= regmem;
                  rec.regn   <= regmem ? 4'd0 : {rex_b, byte_in[2:0]};
                  rec.hibyte <= (rec.size == OSZ_8) && !regmem && !rex_seen && byte_in[2];
                  rec.fault  <= lock && !regmem;
                  rec.is_sub <= (byte_in[5:3] == SUB_EXT) && !(lock && !regmem);
                  st         <= ST_IMM;
               end
            end
            ST_IMM: begin
               if (take && imm_last) st <= ST_EMIT;
            end
            default: st <= ST_SCAN;
         endcase
      end
   end

endmodule

// File: rtl/subimm_decoder.sv
`timescale 1ns/1ps
module subimm_decoder
   import subdec_pkg::*;
#(
   parameter int OUT_W     = 64,
   parameter int IMM_LANES = 4,
   parameter bit REX_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             mode_64,
   input  logic             in_valid,
   input  logic [7:0]       in_byte,
   output logic             in_ready,
   output logic             out_valid,
   output logic [1:0]       out_size,
   output logic             out_mem,
   output logic [3:0]       out_reg,
   output logic             out_hibyte,
   output logic             out_is_sub,
   output logic             out_fault,
   output logic [OUT_W-1:0] out_imm
);

   localparam int LW = $clog2(IMM_LANES + 1);

   generate
      if (IMM_LANES < 4) begin : g_bad_lanes
         $error("IMM_LANES must hold a 32-bit immediate");
      end
      if (OUT_W < 64) begin : g_bad_width
         $error("OUT_W must hold a 64-bit sign-extended immediate");
      end
   endgenerate

   logic          is_prefix, lock, osz16, rex_seen, rex_w, rex_b;
   logic          pfx_take, imm_load, clr, imm_last;
   logic [LW-1:0] len;
   rec_t          rec;

   subdec_prefix #(.REX_EN(REX_EN)) u_prefix (
      .clk       (clk),
      .rst       (rst),
      .mode_64   (mode_64),
      .take      (pfx_take),
      .clr       (clr),
      .byte_in   (in_byte),
      .is_prefix (is_prefix),
      .lock      (lock),
      .osz16     (osz16),
      .rex_seen  (rex_seen),
      .rex_w     (rex_w),
      .rex_b     (rex_b)
   );

   subdec_ctrl #(.LW(LW)) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .byte_in   (in_byte),
      .is_prefix (is_prefix),
      .lock      (lock),
      .osz16     (osz16),
      .rex_seen  (rex_seen),
      .rex_w     (rex_w),
      .rex_b     (rex_b),
      .imm_last  (imm_last),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .pfx_take  (pfx_take),
      .imm_load  (imm_load),
      .clr       (clr),
      .len       (len),
      .rec       (rec)
   );

   subdec_immcol #(.LANES(IMM_LANES), .OUT_W(OUT_W)) u_imm (
      .clk     (clk),
      .rst     (rst),
      .clr     (clr),
      .load    (imm_load),
      .byte_in (in_byte),
      .len     (len),
      .last    (imm_last),
      .value   (out_imm)
   );

   assign out_size   = rec.size;
   assign out_mem    = rec.mem;
   assign out_reg    = rec.regn;
   assign out_hibyte = rec.hibyte;
   assign out_is_sub = rec.is_sub;
   assign out_fault  = rec.fault;

endmodule

// File: rtl/subdec_checks.sv
`timescale 1ns/1ps
module subdec_checks #(
   parameter int OUT_W = 64
) (
   input logic             clk,
   input logic             rst,
   input logic             in_ready,
   input logic             out_valid,
   input logic [1:0]       out_size,
   input logic             out_mem,
   input logic             out_hibyte,
   input logic             out_is_sub,
   input logic             out_fault,
   input logic [OUT_W-1:0] out_imm
);

   p_one_pulse_r9: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

   p_ready_low_r8: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> !in_ready);

   p_fault_reg_r7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_fault) |-> !out_mem);

   p_fault_nosub_r7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_fault) |-> !out_is_sub);

   p_hibyte_r5: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_hibyte) |-> (out_size == 2'd0 && !out_mem));

   p_sext8_r6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_size == 2'd0) |->
         ($countones(out_imm[OUT_W-1:7]) == 0 || $countones(out_imm[OUT_W-1:7]) == OUT_W - 7));

   p_sext16_r6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_size == 2'd1) |->
         ($countones(out_imm[OUT_W-1:15]) == 0 || $countones(out_imm[OUT_W-1:15]) == OUT_W - 15));

   p_sext32_r6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_size[1]) |->
         ($countones(out_imm[OUT_W-1:31]) == 0 || $countones(out_imm[OUT_W-1:31]) == OUT_W - 31));

endmodule

bind subimm_decoder subdec_checks #(.OUT_W(OUT_W)) u_checks (
   .clk        (clk),
   .rst        (rst),
   .in_ready   (in_ready),
   .out_valid  (out_valid),
   .out_size   (out_size),
   .out_mem    (out_mem),
   .out_hibyte (out_hibyte),
   .out_is_sub (out_is_sub),
   .out_fault  (out_fault),
   .out_imm    (out_imm)
);

// File: tb/tb_subimm_decoder.sv
`timescale 1ns/1ps
module tb_subimm_decoder;

   logic        clk = 1'b0;
   logic        rst, mode_64, in_valid;
   logic [7:0]  in_byte;
   logic        in_ready, out_valid, out_mem, out_hibyte, out_is_sub, out_fault;
   logic [1:0]  out_size;
   logic [3:0]  out_reg;
   logic [63:0] out_imm;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   subimm_decoder dut (
      .clk(clk), .rst(rst), .mode_64(mode_64), .in_valid(in_valid), .in_byte(in_byte),
      .in_ready(in_ready), .out_valid(out_valid), .out_size(out_size), .out_mem(out_mem),
      .out_reg(out_reg), .out_hibyte(out_hibyte), .out_is_sub(out_is_sub),
      .out_fault(out_fault), .out_imm(out_imm)
   );

   function automatic logic [63:0] sx8(input logic [7:0] v);
      return {{56{v[7]}}, v};
   endfunction
   function automatic logic [63:0] sx16(input logic [15:0] v);
      return {{48{v[15]}}, v};
   endfunction
   function automatic logic [63:0] sx32(input logic [31:0] v);
      return {{32{v[31]}}, v};
   endfunction

   task automatic push(input logic [7:0] b, input bit gap);
      @(negedge clk);
      if (gap) begin
         in_valid = 1'b0;
         in_byte  = b ^ 8'hC3;
         @(negedge clk);
      end
      in_valid = 1'b1;
      in_byte  = b;
   endtask

   task automatic expect_rec(input string req, input logic [1:0] sz, input logic mem,
                             input logic [3:0] rg, input logic hib, input logic sub,
                             input logic flt, input logic [63:0] imm);
      logic [75:0] got, exp;
      @(negedge clk);
      in_valid = 1'b0;
      got = {out_valid, in_ready, out_size, out_mem, out_reg, out_hibyte, out_is_sub, out_fault, out_imm};
      exp = {1'b1, 1'b0, sz, mem, rg, hib, sub, flt, imm};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic expect_idle(input string req);
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
         errors++;
         $display("FAIL %s: got valid=%b ready=%b expected valid=0 ready=1", req, out_valid, in_ready);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got no finish expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1; mode_64 = 1'b1; in_valid = 1'b0; in_byte = 8'h00;
      repeat (3) @(negedge clk);
      // R11: reset state
      checks++;
      if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
         errors++;
         $display("FAIL R11 reset: got valid=%b ready=%b expected 0 1", out_valid, in_ready);
      end
      rst = 1'b0;

      // R2 R6: all 8-bit accumulator immediates
      for (int k = 0; k < 256; k++) begin
         push(8'h2C, 0); push(8'(k), 0);
         expect_rec("R2 R6 acc8", 2'd0, 0, 4'd0, 0, 1, 0, sx8(8'(k)));
      end
      expect_idle("R9 pulse after acc8");

      // R4 R5 R6: 0x80 with every ModRM, with and without REX.B
      for (int k = 0; k < 512; k++) begin
         logic [7:0] m;
         logic r, mem;
         m = 8'(k);
         r = (k >= 256);
         mem = (m[7:6] != 2'b11);
         if (r) push(8'h41, 0);
         push(8'h80, 0); push(m, 0); push(m ^ 8'h5A, 0);
         expect_rec("R4 R5 grp8", 2'd0, mem, mem ? 4'd0 : {r, m[2:0]},
                    !mem && !r && m[2], m[5:3] == 3'd5, 0, sx8(m ^ 8'h5A));
      end
      expect_idle("R9 pulse after grp8");

      // R3 R4 R5 R6: 0x81 across every ModRM and size combination
      for (int k = 0; k < 256; k++) begin
         logic [7:0] m, b0, b1, b2, b3;
         logic [1:0] sz;
         logic rb, mem;
         m = 8'(k); b0 = 8'(k); b1 = ~b0; b2 = b0 + 8'd1; b3 = b0 ^ 8'h80;
         mem = (m[7:6] != 2'b11);
         rb = 1'b0;
         case (k % 4)
            0: sz = 2'd2;
            1: begin push(8'h66, 0); sz = 2'd1; end
            2: begin push(8'h48, 0); sz = 2'd3; end
            default: begin push(8'h66, 0); push(8'h49, 0); sz = 2'd3; rb = 1'b1; end
         endcase
         push(8'h81, 0); push(m, 0); push(b0, 0); push(b1, 0);
         if (sz != 2'd1) begin push(b2, 0); push(b3, 0); end
         expect_rec("R3 R4 grpw", sz, mem, mem ? 4'd0 : {rb, m[2:0]}, 0, m[5:3] == 3'd5, 0,
                    (sz == 2'd1) ? sx16({b1, b0}) : sx32({b3, b2, b1, b0}));
      end

      // R3: accumulator wide forms
      push(8'h66, 0); push(8'h2D, 0); push(8'h00, 0); push(8'h80, 0);
      expect_rec("R3 acc16", 2'd1, 0, 4'd0, 0, 1, 0, 64'hFFFF_FFFF_FFFF_8000);
      push(8'h2D, 0); push(8'hFF, 0); push(8'hFF, 0); push(8'hFF, 0); push(8'h7F, 0);
      expect_rec("R3 acc32", 2'd2, 0, 4'd0, 0, 1, 0, 64'h0000_0000_7FFF_FFFF);
      push(8'h48, 0); push(8'h2D, 0); push(8'h00, 0); push(8'h00, 0); push(8'h00, 0); push(8'h80, 0);
      expect_rec("R3 R6 acc64", 2'd3, 0, 4'd0, 0, 1, 0, 64'hFFFF_FFFF_8000_0000);
      push(8'h66, 0); push(8'h48, 0); push(8'h2D, 0); push(8'h01, 0); push(8'h02, 0); push(8'h03, 0); push(8'h04, 0);
      expect_rec("R3 W over 66", 2'd3, 0, 4'd0, 0, 1, 0, 64'h0000_0000_0403_0201);

      // R1: REX followed by another prefix is cancelled
      push(8'h48, 0); push(8'h66, 0); push(8'h2D, 0); push(8'h34, 0); push(8'h92, 0);
      expect_rec("R1 rex cancel", 2'd1, 0, 4'd0, 0, 1, 0, 64'hFFFF_FFFF_FFFF_9234);
      push(8'h41, 0); push(8'hF0, 0); push(8'h80, 0); push(8'h2C, 0); push(8'h11, 0);
      expect_rec("R1 R7 rex cancel lock mem", 2'd0, 1, 4'd0, 0, 1, 0, 64'h11);

      // R7: lock handling
      push(8'hF0, 0); push(8'h80, 0); push(8'hC5, 0); push(8'h7F, 0);
      expect_rec("R7 lock reg", 2'd0, 0, 4'd5, 1, 0, 1, 64'h7F);
      push(8'hF0, 0); push(8'h80, 0); push(8'h2D, 0); push(8'h80, 0);
      expect_rec("R7 lock mem", 2'd0, 1, 4'd0, 0, 1, 0, 64'hFFFF_FFFF_FFFF_FF80);
      push(8'hF0, 0); push(8'h2C, 0); push(8'h01, 0);
      expect_rec("R7 lock acc8", 2'd0, 0, 4'd0, 0, 0, 1, 64'h01);
      push(8'hF0, 0); push(8'h48, 0); push(8'h2D, 0); push(8'h05, 0); push(8'h00, 0); push(8'h00, 0); push(8'h00, 0);
      expect_rec("R7 lock acc64", 2'd3, 0, 4'd0, 0, 0, 1, 64'h05);
      push(8'hF0, 0); push(8'h81, 0); push(8'hD8, 0); push(8'h01, 0); push(8'h00, 0); push(8'h00, 0); push(8'h00, 0);
      expect_rec("R7 lock reg nonsub", 2'd2, 0, 4'd0, 0, 0, 1, 64'h01);

      // R10: other opcodes, and REX range outside 64-bit mode
      push(8'h90, 0);
      expect_rec("R10 other opcode", 2'd0, 0, 4'd0, 0, 0, 0, 64'h0);
      expect_idle("R9 pulse after other");
      mode_64 = 1'b0;
      push(8'h48, 0);
      expect_rec("R10 rex byte legacy", 2'd0, 0, 4'd0, 0, 0, 0, 64'h0);
      push(8'h2D, 0); push(8'h00, 0); push(8'h00, 0); push(8'h00, 0); push(8'hF0, 0);
      expect_rec("R10 legacy acc32", 2'd2, 0, 4'd0, 0, 1, 0, 64'hFFFF_FFFF_F000_0000);
      mode_64 = 1'b1;

      // R8: idle gaps with junk on the byte lines
      push(8'h81, 1); push(8'hE9, 1); push(8'h10, 1); push(8'h20, 1); push(8'h30, 1); push(8'h40, 1);
      expect_rec("R8 gaps", 2'd2, 0, 4'd1, 0, 1, 0, 64'h4030_2010);
      expect_idle("R9 pulse after gaps");

      // R11: reset in the middle of an instruction
      push(8'h66, 0); push(8'h81, 0); push(8'hE8, 0);
      @(negedge clk);
      in_valid = 1'b0; rst = 1'b1;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R11 reset mid: got valid=%b expected 0", out_valid);
      end
      rst = 1'b0;
      push(8'h81, 0); push(8'hE8, 0); push(8'h01, 0); push(8'h00, 0); push(8'h00, 0); push(8'h00, 0);
      expect_rec("R11 prefixes dropped", 2'd2, 0, 4'd0, 0, 1, 0, 64'h01);
      expect_idle("R9 back to scan");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule